// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single access requests from an on-chip master into cycles on a simple external processor bus. Every access, read or write, has the same shape. A setup phase presents address, chip select and direction. A transfer phase then moves the data and ends the access. Reads and writes differ only in which strobe goes low and in whether the block drives the data bus.

Wait states stretch an access by repeating the setup phase; the transfer phase is never held. Each request carries an automatic wait count of 0 to 7. That many extra setup cycles are inserted with no help from outside. After that, an active-low ready pin is sampled at the end of every setup cycle, and setup keeps repeating while ready is high. A new request can be taken during the transfer phase of the current access, so a read may run straight into a write with no idle gap. Read data and a one-cycle done pulse appear in the cycle after the transfer phase.

Top module: `xbus_cycle_seq`

## Requirements
- R1: After reset, bus_cs_n, bus_rd_n and bus_wr_n are 1, bus_doe and rsp_done are 0, and req_ready is 1.
- R2: A read accepted with wait count 0 and bus_rdy_n low holds bus_cs_n and bus_rd_n low for exactly two cycles, starting in the cycle after acceptance; bus_wr_n and bus_doe stay inactive.
- R3: A write holds bus_cs_n low and bus_doe high with bus_dout equal to the request data for the whole access, keeps bus_rd_n high, and drives bus_wr_n low only in the final (transfer) cycle.
- R4: An access with automatic wait count N (0 to 7) and ready asserted lasts 2+N cycles.
- R5: Once the automatic count is exhausted, each setup cycle whose closing edge sees bus_rdy_n high adds one more cycle to the access.
- R6: bus_rdy_n is ignored during automatic wait cycles: an access with count N and ready high for only its first N cycles still lasts 2+N cycles.
- R7: req_ready is 1 only when idle or in a transfer cycle; a request held during setup cycles is not taken, and bus_addr keeps the current access's address.
- R8: A request accepted in a transfer cycle starts its setup phase in the next cycle with bus_cs_n staying low, so a read can be followed by a write with no gap.
- R9: bus_addr is constant for every cycle of an access.
- R10: rsp_done is high for exactly one cycle, the cycle after each transfer cycle; for a read, rsp_rdata then holds the bus_din value sampled at the end of the transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_waits | input | WAIT_W | Automatic wait cycles for the selected area |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Data driven to the bus |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data read from the bus |
| bus_rdy_n | input | 1 | External ready, active low |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
A wait counter that is off by one changes the number of cycles bus_cs_n stays low, and that shows by the end of the same access. A phase register that sees ready too early or too late lengthens or shortens an access relative to 2 + max(N, ready-high cycles). A bad strobe decode shows within a single cycle as the wrong strobe or a write strobe outside the last cycle. A faulty accept window shows as a changed bus_addr during setup, or as an idle gap between back-to-back accesses, by the next access at the latest.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_XFER  = 2'd2
  } phase_t;
endpackage

// File: rtl/xbs_wait_ctr.sv
module xbs_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              zero
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4: each automatic wait cycle removes exactly one from the count
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (cnt_q == WAIT_W'($past(cnt_q) - 1'b1)));

  // R4: a new access starts from its own requested count
  a_r4_count_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/xbs_phase_fsm.sv
module xbs_phase_fsm
  import xbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   waits_zero,
  input  logic   rdy_n,
  output phase_t phase_q,
  output phase_t phase_nxt,
  output logic   accept,
  output logic   req_ready,
  output logic   ctr_dec,
  output logic   xfer_end
);
  assign req_ready = (phase_q == PH_IDLE) || (phase_q == PH_XFER);
  assign accept    = req_valid && req_ready;
  assign ctr_dec   = (phase_q == PH_SETUP) && !waits_zero;
  assign xfer_end  = (phase_q == PH_XFER);

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (accept) phase_nxt = PH_SETUP;
      PH_SETUP: begin
        if (!waits_zero)  phase_nxt = PH_SETUP;
        else if (rdy_n)   phase_nxt = PH_SETUP;
        else              phase_nxt = PH_XFER;
      end
      PH_XFER:  phase_nxt = accept ? PH_SETUP : PH_IDLE;
      default:  phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

  // R4: setup repeats while automatic waits remain
  a_r4_auto_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP && !waits_zero) |=> (phase_q == PH_SETUP));

  // R5: setup repeats while ready is withheld after the count is spent
  a_r5_rdy_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP && waits_zero && rdy_n) |=> (phase_q == PH_SETUP));

  // R2: a started access never falls back to idle from setup
  a_r2_no_abort: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP) |=> (phase_q != PH_IDLE));

  // R10: the transfer phase lasts a single cycle
  a_r10_xfer_once: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_XFER) |=> (phase_q != PH_XFER));
endmodule

// File: rtl/xbs_pin_regs.sv
module xbs_pin_regs
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_t            phase_nxt,
  input  logic              xfer_end,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic wr_q;
  logic wr_sel;
  logic busy_nxt;

  assign wr_sel   = accept ? req_write : wr_q;
  assign busy_nxt = (phase_nxt != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      bus_addr <= '0;
      bus_dout <= '0;
    end else if (accept) begin
      wr_q     <= req_write;
      bus_addr <= req_addr;
      bus_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_doe  <= 1'b0;
    end else begin
      bus_cs_n <= !busy_nxt;
      bus_rd_n <= !(busy_nxt && !wr_sel);
      bus_wr_n <= !((phase_nxt == PH_XFER) && wr_sel);
      bus_doe  <= busy_nxt && wr_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= xfer_end;
      if (xfer_end && !wr_q) rsp_rdata <= bus_din;
    end
  end

  // R3: the two strobes are never low together
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  // R3: the write strobe only falls while the data bus is driven
  a_r3_wr_driven: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_doe);

  // R9: address and write data hold while an access runs
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !accept) |=> ($stable(bus_addr) && $stable(bus_dout)));

  // R10: completion pulse is a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] req_waits,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy_n,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  phase_t phase_q;
  phase_t phase_nxt;
  logic   accept;
  logic   ctr_dec;
  logic   waits_zero;
  logic   xfer_end;

  xbs_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (req_waits),
    .dec      (ctr_dec),
    .zero     (waits_zero)
  );

  xbs_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .waits_zero (waits_zero),
    .rdy_n      (bus_rdy_n),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .req_ready  (req_ready),
    .ctr_dec    (ctr_dec),
    .xfer_end   (xfer_end)
  );

  xbs_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phase_nxt (phase_nxt),
    .xfer_end  (xfer_end),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  // R1/R8: chip select is low in every setup and transfer cycle
  a_r8_cs_active: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |-> !bus_cs_n);
endmodule

// File: tb/xbus_cycle_seq_test.sv
module xbus_cycle_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [WW-1:0] req_waits = '0;
  logic [AW-1:0] bus_addr;
  logic          bus_cs_n, bus_rd_n, bus_wr_n, bus_doe;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic          bus_rdy_n = 1'b0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_waits(req_waits), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(bus_cs_n == 1'b1, "R1 cs_n", bus_cs_n, 1);
    chk(bus_rd_n == 1'b1 && bus_wr_n == 1'b1, "R1 strobes", {bus_rd_n, bus_wr_n}, 3);
    chk(bus_doe == 1'b0, "R1 doe", bus_doe, 0);
    chk(rsp_done == 1'b0, "R1 done", rsp_done, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
  endtask

  // Single access; ready is held high for the first hi cycles of the access.
  task automatic t_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int nw, input int hi, input logic [DW-1:0] din, input string rq);
    int len = 0;
    int wlow = 0;
    int last_w = 0;
    bit strobe_ok = 1;
    bit addr_ok = 1;
    int exp_len;
    exp_len = 2 + ((hi > nw) ? hi : nw);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    req_waits = WW'(nw); bus_din = din; bus_rdy_n = 1'b1;
    chk(req_ready == 1'b1, {rq, " R7 ready idle"}, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_done) break;
      if (!bus_cs_n) begin
        len++;
        if (bus_addr != a) addr_ok = 0;
        if (wr) begin
          if (!bus_wr_n) begin wlow++; last_w = len; end
          if (!bus_doe || bus_dout != wd || !bus_rd_n) strobe_ok = 0;
        end else begin
          if (bus_rd_n || !bus_wr_n || bus_doe) strobe_ok = 0;
        end
      end
      bus_rdy_n = (len <= hi);
      @(negedge clk);
    end
    chk(rsp_done == 1'b1, {rq, " R10 done seen"}, rsp_done, 1);
    chk(len == exp_len, {rq, " R4/R5/R6 length"}, len, exp_len);
    chk(bus_cs_n == 1'b1, {rq, " R2 cs released"}, bus_cs_n, 1);
    chk(addr_ok, {rq, " R9 addr stable"}, addr_ok, 1);
    if (wr) begin
      chk(strobe_ok, {rq, " R3 write strobes"}, strobe_ok, 1);
      chk(wlow == 1 && last_w == len, {rq, " R3 wr_n last cycle"}, last_w, len);
    end else begin
      chk(strobe_ok, {rq, " R2 read strobes"}, strobe_ok, 1);
      chk(rsp_rdata == din, {rq, " R10 rdata"}, rsp_rdata, din);
    end
    bus_rdy_n = 1'b0;
    @(negedge clk);
    chk(rsp_done == 1'b0, {rq, " R10 done one cycle"}, rsp_done, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00A0B0;
    req_waits = '0; bus_din = 16'hC3A5; bus_rdy_n = 1'b0;
    @(negedge clk);  // setup of the read
    chk(req_ready == 1'b0, "R7 not ready in setup", req_ready, 0);
    chk(bus_addr == 24'h00A0B0 && !bus_rd_n, "R2 read setup", bus_addr, 24'h00A0B0);
    req_write = 1'b1; req_addr = 24'h123456; req_wdata = 16'h5AF0; req_waits = '0;
    @(negedge clk);  // transfer of the read
    chk(req_ready == 1'b1, "R7 ready in transfer", req_ready, 1);
    chk(bus_addr == 24'h00A0B0, "R7 held request ignored", bus_addr, 24'h00A0B0);
    @(negedge clk);  // setup of the write
    req_valid = 1'b0;
    chk(bus_cs_n == 1'b0, "R8 no idle gap", bus_cs_n, 0);
    chk(bus_addr == 24'h123456, "R8 write address", bus_addr, 24'h123456);
    chk(bus_rd_n && bus_wr_n && bus_doe, "R3 write setup strobes", {bus_rd_n, bus_wr_n, bus_doe}, 7);
    chk(rsp_done == 1'b1, "R10 read done during next setup", rsp_done, 1);
    chk(rsp_rdata == 16'hC3A5, "R10 read data", rsp_rdata, 16'hC3A5);
    @(negedge clk);  // transfer of the write
    chk(!bus_wr_n && bus_dout == 16'h5AF0, "R3 write transfer", bus_dout, 16'h5AF0);
    chk(rsp_done == 1'b0, "R10 done cleared", rsp_done, 0);
    @(negedge clk);
    chk(bus_cs_n == 1'b1 && rsp_done == 1'b1, "R8 write completes", {bus_cs_n, rsp_done}, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_access(1'b0, 24'h000100, 16'h0000, 0, 0, 16'hBEEF, "read0");
    t_access(1'b1, 24'h000204, 16'h1234, 0, 0, 16'h0000, "write0");
    t_access(1'b0, 24'h00F000, 16'h0000, 3, 0, 16'h7E57, "read auto3");
    t_access(1'b1, 24'h0ABCDE, 16'hA55A, 7, 0, 16'h0000, "write auto7");
    t_access(1'b0, 24'h001111, 16'h0000, 0, 2, 16'h0F0F, "read R5 rdy2");
    t_access(1'b0, 24'h002222, 16'h0000, 4, 4, 16'h3C3C, "read R6 rdy during auto");
    t_access(1'b1, 24'h003333, 16'h9999, 2, 5, 16'h0000, "write R5 auto2 rdy5");
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule